// File: doc/BRIEF.md
# Two-Stage Top-Two Track Selector

This block takes one word per track-finding cluster of a trigger sector every clock and reports the two tracks with the highest momentum level. Each word carries a momentum level and a charge bit. The cluster's index is the track's position coordinate. The number of clusters is a parameter, so one design covers both the large and the small sector variants.

Selection runs in two stages.

- **Pre-selection.** A bank of pre-selectors, one for each momentum level, looks only at the clusters that report its own level. Each one keeps the two of them with the smallest cluster indices.
- **Final selection.** A final selector looks at the twelve surviving candidates and picks the two of highest level.

The block is registered after each stage. It accepts a new event on every clock, with no dead cycles.

Top module: `trksel_top`

## Requirements
- R1: The first output (`best_*`) carries the highest level present among the inputs. Valid levels are 1 to 6.
- R2: The second output (`next_*`) carries the next track in ranking order. If two or more tracks share the top level, both outputs come from that level. Its level never exceeds the first output's level.
- R3: Among tracks of equal level, the lower cluster index ranks first. When both outputs have the same nonzero level, `best_idx_o` is smaller than `next_idx_o`.
- R4: The input word is laid out as follows. Cluster k occupies bits 4k+3..4k of `trk_i`. Bits 4k+2..4k hold the level and bit 4k+3 holds the charge. Level 0 means no track. Level 7 is not a valid level and is ignored like an empty slot.
- R5: An output with no track reports level 0, charge 0 and index 0.
- R6: Latency is exactly 2 clocks. An event applied before clock edge n appears on the outputs after edge n+1. Events may arrive on every clock.
- R7: The charge and index reported with a selected track are the charge bit and the cluster index of the input word it came from.
- R8: While `rst_n` is low, and for the two clocks after it is released with empty inputs, both outputs read level 0.
- R9: A track on the last cluster (index N_CLUST-1) is selectable like any other cluster.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trk_i | input | 4*N_CLUST (92) | Per-cluster track words |
| best_lvl_o | output | 3 | Level of the highest-ranked track, 0 if none |
| best_chg_o | output | 1 | Charge of the highest-ranked track |
| best_idx_o | output | IDX_W (5) | Cluster index of the highest-ranked track |
| next_lvl_o | output | 3 | Level of the second-ranked track, 0 if none |
| next_chg_o | output | 1 | Charge of the second-ranked track |
| next_idx_o | output | IDX_W (5) | Cluster index of the second-ranked track |

## Verification
The bench concentrates on the following corner cases.

- **Three or more tracks on one level.** A design that kept the wrong pair, or ranked by the higher index, would report a later cluster.
- **Two tracks on the top level with a lower level also present.** A design that forced the outputs onto different levels would put the lower-level track second.
- **Level 7 words and charge set on empty words.** A design that treated nonzero as valid would report a phantom track, or leak the charge onto an empty output.
- **A track only on the last cluster.** This exposes an off-by-one in the cluster scan.
- **Back-to-back random events compared every cycle.** A design with a wrong pipeline depth, or with events mixed across cycles, would show a mismatch.

// File: rtl/trksel_pkg.sv
package trksel_pkg;
  localparam int LVL_W  = 3;
  localparam int WORD_W = LVL_W + 1;
  localparam int N_LVL  = 6;
  localparam int N_CAND = 2 * N_LVL;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/trksel_presel.sv
// One pre-selector: keeps the two lowest-index clusters reporting LEVEL.
module trksel_presel
  import trksel_pkg::*;
#(
  parameter int N_CLUST = 23,
  parameter int IDX_W   = 5,
  parameter int LEVEL   = 1
) (
  input  logic [N_CLUST*WORD_W-1:0] trk_i,
  output logic [1:0]                vld_o,
  output logic [1:0]                chg_o,
  output logic [2*IDX_W-1:0]        idx_o
);
  always_comb begin
    vld_o = '0;
    chg_o = '0;
    idx_o = '0;
    for (int k = 0; k < N_CLUST; k++) begin
      if (trk_i[k*WORD_W +: LVL_W] == lvl_t'(LEVEL)) begin
        if (!vld_o[0]) begin
          vld_o[0]          = 1'b1;
          chg_o[0]          = trk_i[k*WORD_W + LVL_W];
          idx_o[0 +: IDX_W] = IDX_W'(k);
        end else if (!vld_o[1]) begin
          vld_o[1]              = 1'b1;
          chg_o[1]              = trk_i[k*WORD_W + LVL_W];
          idx_o[IDX_W +: IDX_W] = IDX_W'(k);
        end
      end
    end
  end
endmodule

// File: rtl/trksel_final.sv
// Final selector: the two best of the per-level candidate pairs.
// Candidate c = 2*(level-1) + slot; slot 0 holds the lower index.
module trksel_final
  import trksel_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [N_CAND-1:0]       vld_i,
  input  logic [N_CAND-1:0]       chg_i,
  input  logic [N_CAND*IDX_W-1:0] idx_i,
  output lvl_t                    lvl0_o,
  output logic                    chg0_o,
  output logic [IDX_W-1:0]        idx0_o,
  output lvl_t                    lvl1_o,
  output logic                    chg1_o,
  output logic [IDX_W-1:0]        idx1_o
);
  always_comb begin
    lvl0_o = '0;
    chg0_o = 1'b0;
    idx0_o = '0;
    lvl1_o = '0;
    chg1_o = 1'b0;
    idx1_o = '0;
    for (int l = N_LVL; l >= 1; l--) begin
      for (int s = 0; s < 2; s++) begin
        if (vld_i[(l-1)*2+s]) begin
          if (lvl0_o == '0) begin
            lvl0_o = lvl_t'(l);
            chg0_o = chg_i[(l-1)*2+s];
            idx0_o = idx_i[((l-1)*2+s)*IDX_W +: IDX_W];
          end else if (lvl1_o == '0) begin
            lvl1_o = lvl_t'(l);
            chg1_o = chg_i[(l-1)*2+s];
            idx1_o = idx_i[((l-1)*2+s)*IDX_W +: IDX_W];
          end
        end
      end
    end
  end
endmodule

// File: rtl/trksel_top.sv
module trksel_top
  import trksel_pkg::*;
#(
  parameter int N_CLUST = 23,
  localparam int IDX_W  = (N_CLUST > 1) ? $clog2(N_CLUST) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_CLUST*WORD_W-1:0] trk_i,
  output logic [LVL_W-1:0]          best_lvl_o,
  output logic                      best_chg_o,
  output logic [IDX_W-1:0]          best_idx_o,
  output logic [LVL_W-1:0]          next_lvl_o,
  output logic                      next_chg_o,
  output logic [IDX_W-1:0]          next_idx_o
);
  logic [N_CAND-1:0]       pre_vld, s1_vld, s1_vld_d;
  logic [N_CAND-1:0]       pre_chg, s1_chg, s1_chg_d;
  logic [N_CAND*IDX_W-1:0] pre_idx, s1_idx, s1_idx_d;

  // Stage 1: one pre-selector per level
  for (genvar g = 0; g < N_LVL; g++) begin : g_pre
    trksel_presel #(
      .N_CLUST(N_CLUST),
      .IDX_W  (IDX_W),
      .LEVEL  (g + 1)
    ) u_pre (
      .trk_i (trk_i),
      .vld_o (pre_vld[2*g +: 2]),
      .chg_o (pre_chg[2*g +: 2]),
      .idx_o (pre_idx[2*g*IDX_W +: 2*IDX_W])
    );
  end

  always_comb begin
    s1_vld_d = pre_vld;
    s1_chg_d = pre_chg;
    s1_idx_d = pre_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= '0;
      s1_chg <= '0;
      s1_idx <= '0;
    end else begin
      s1_vld <= s1_vld_d;
      s1_chg <= s1_chg_d;
      s1_idx <= s1_idx_d;
    end
  end

  // Stage 2: final 12-to-2 selection
  lvl_t             f_lvl0, f_lvl1;
  logic             f_chg0, f_chg1;
  logic [IDX_W-1:0] f_idx0, f_idx1;

  trksel_final #(.IDX_W(IDX_W)) u_final (
    .vld_i  (s1_vld),
    .chg_i  (s1_chg),
    .idx_i  (s1_idx),
    .lvl0_o (f_lvl0),
    .chg0_o (f_chg0),
    .idx0_o (f_idx0),
    .lvl1_o (f_lvl1),
    .chg1_o (f_chg1),
    .idx1_o (f_idx1)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_lvl_o <= '0;
      best_chg_o <= 1'b0;
      best_idx_o <= '0;
      next_lvl_o <= '0;
      next_chg_o <= 1'b0;
      next_idx_o <= '0;
    end else begin
      best_lvl_o <= f_lvl0;
      best_chg_o <= f_chg0;
      best_idx_o <= f_idx0;
      next_lvl_o <= f_lvl1;
      next_chg_o <= f_chg1;
      next_idx_o <= f_idx1;
    end
  end
endmodule

// File: rtl/trksel_chk.sv
module trksel_chk
  import trksel_pkg::*;
#(
  parameter int N_CLUST = 23,
  localparam int IDX_W  = (N_CLUST > 1) ? $clog2(N_CLUST) : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [N_CLUST*WORD_W-1:0] trk_i,
  input logic [LVL_W-1:0]          best_lvl_o,
  input logic                      best_chg_o,
  input logic [IDX_W-1:0]          best_idx_o,
  input logic [LVL_W-1:0]          next_lvl_o,
  input logic                      next_chg_o,
  input logic [IDX_W-1:0]          next_idx_o
);
  lvl_t       in_max, max_d1, max_d2;
  logic [1:0] age;
  logic       ready;

  always_comb begin
    in_max = '0;
    for (int k = 0; k < N_CLUST; k++) begin
      if (trk_i[k*WORD_W +: LVL_W] <= lvl_t'(N_LVL) &&
          trk_i[k*WORD_W +: LVL_W] > in_max)
        in_max = trk_i[k*WORD_W +: LVL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_d1 <= '0;
      max_d2 <= '0;
      age    <= '0;
    end else begin
      max_d1 <= in_max;
      max_d2 <= max_d1;
      if (age != 2'd2) age <= age + 2'd1;
    end
  end

  assign ready = (age == 2'd2);

  // R1
  best_is_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> best_lvl_o == max_d2);
  // R2
  next_not_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    next_lvl_o <= best_lvl_o);
  // R3
  tie_low_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (best_lvl_o == next_lvl_o && next_lvl_o != '0) |-> best_idx_o < next_idx_o);
  // R4
  lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    best_lvl_o <= lvl_t'(N_LVL));
  // R5
  empty_best_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    best_lvl_o == '0 |-> (!best_chg_o && best_idx_o == '0));
  // R5
  empty_next_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    next_lvl_o == '0 |-> (!next_chg_o && next_idx_o == '0));
  // R8
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (best_lvl_o == '0 && next_lvl_o == '0));
endmodule

bind trksel_top trksel_chk #(.N_CLUST(N_CLUST)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trk_i      (trk_i),
  .best_lvl_o (best_lvl_o),
  .best_chg_o (best_chg_o),
  .best_idx_o (best_idx_o),
  .next_lvl_o (next_lvl_o),
  .next_chg_o (next_chg_o),
  .next_idx_o (next_idx_o)
);

// File: tb/trksel_top_tb.sv
module trksel_top_tb;
  localparam int N  = 23;
  localparam int IW = $clog2(N);

  typedef struct packed {
    logic [2:0]    l0;
    logic          c0;
    logic [IW-1:0] i0;
    logic [2:0]    l1;
    logic          c1;
    logic [IW-1:0] i1;
  } res_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N*4-1:0] trk = '0;
  logic [2:0]     bl, nl;
  logic           bc, nc;
  logic [IW-1:0]  bi, ni;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  res_t q[$];
  string tq[$];

  always #10 clk = ~clk;

  trksel_top #(.N_CLUST(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .trk_i(trk),
    .best_lvl_o(bl), .best_chg_o(bc), .best_idx_o(bi),
    .next_lvl_o(nl), .next_chg_o(nc), .next_idx_o(ni)
  );

  function automatic res_t model(input logic [N*4-1:0] v);
    res_t r = '0;
    int   n = 0;
    for (int lv = 6; lv >= 1; lv--) begin
      for (int k = 0; k < N; k++) begin
        if (int'(v[k*4 +: 3]) == lv && n < 2) begin
          if (n == 0) begin
            r.l0 = 3'(lv); r.c0 = v[k*4+3]; r.i0 = IW'(k);
          end else begin
            r.l1 = 3'(lv); r.c1 = v[k*4+3]; r.i1 = IW'(k);
          end
          n++;
        end
      end
    end
    return r;
  endfunction

  function automatic res_t actual();
    res_t r;
    r.l0 = bl; r.c0 = bc; r.i0 = bi;
    r.l1 = nl; r.c1 = nc; r.i1 = ni;
    return r;
  endfunction

  task automatic check(input string tag, input res_t got, input res_t exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got best=%0d/%0d/%0d next=%0d/%0d/%0d exp best=%0d/%0d/%0d next=%0d/%0d/%0d",
               tag, got.l0, got.c0, got.i0, got.l1, got.c1, got.i1,
               exp.l0, exp.c0, exp.i0, exp.l1, exp.c1, exp.i1);
    end
  endtask

  // one event per clock; compares the event applied two steps earlier (R6)
  task automatic step(input logic [N*4-1:0] v, input string tag);
    @(negedge clk);
    check(tq.pop_front(), actual(), q.pop_front());
    trk = v;
    q.push_back(model(v));
    tq.push_back(tag);
  endtask

  function automatic logic [N*4-1:0] put(input logic [N*4-1:0] v, input int k,
                                         input int lv, input bit c);
    logic [N*4-1:0] r = v;
    r[k*4 +: 4] = {c, 3'(lv)};
    return r;
  endfunction

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [N*4-1:0] v;
    // R8: outputs zero while reset is held
    repeat (2) begin
      @(negedge clk);
      check("R8 in reset", actual(), '0);
    end
    trk = '0;
    @(negedge clk);
    rst_n = 1'b1;
    q.push_back('0); tq.push_back("R8 after release");
    q.push_back('0); tq.push_back("R8 after release");

    // R5: empty event, and charge set on level-0 words
    step('0, "R5 empty");
    v = put('0, 4, 0, 1'b1);
    step(v, "R5 charge on empty word");
    // R4: level 7 is ignored
    v = put('0, 2, 7, 1'b1); v = put(v, 9, 7, 1'b0);
    step(v, "R4 level seven ignored");
    v = put(v, 15, 2, 1'b1);
    step(v, "R4 level seven with real track");
    // R1/R7: single track
    v = put('0, 6, 3, 1'b1);
    step(v, "R1 single track");
    // R2: two levels
    v = put('0, 1, 2, 1'b0); v = put(v, 20, 5, 1'b1);
    step(v, "R2 two levels");
    // R3: three on one level, lower indices win
    v = put('0, 17, 4, 1'b1); v = put(v, 3, 4, 1'b0); v = put(v, 11, 4, 1'b1);
    step(v, "R3 three same level");
    // R2: two at top level beat a lower one
    v = put('0, 0, 1, 1'b1); v = put(v, 8, 6, 1'b0); v = put(v, 5, 6, 1'b1);
    step(v, "R2 two top-level tracks");
    // R1: all levels present
    v = '0;
    for (int k = 0; k < 6; k++) v = put(v, 2*k + 1, k + 1, k[0]);
    step(v, "R1 all levels");
    // R9: last cluster only, and last cluster tied with first
    v = put('0, N-1, 3, 1'b1);
    step(v, "R9 last cluster");
    v = put(v, 0, 3, 1'b0);
    step(v, "R9 first and last tied");
    // R7: every cluster full at one level
    v = '0;
    for (int k = 0; k < N; k++) v = put(v, k, 2, k[1]);
    step(v, "R7 all clusters level two");
    // R6: back-to-back random events
    for (int e = 0; e < 400; e++) begin
      v = '0;
      for (int k = 0; k < N; k++)
        if ($urandom_range(0, 3) == 0) v[k*4 +: 4] = 4'($urandom_range(0, 15));
      step(v, "R6 random burst");
    end
    step('0, "R6 drain");
    step('0, "R6 drain");
    step('0, "R5 drain");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule